// File: doc/BRIEF.md
# Multiplexed ADC Channel Sequencer

This block is the digital steering logic in front of a 16-input multiplexed converter. Each serial transfer hands it one 16-bit control word. From that word and its own stored state, the block picks the analog channel for the conversion that goes with this transfer. It drives that channel onto the multiplexer select lines and raises a conversion request. When the converter reports its 12-bit straight-binary result, the block tags the result with the channel number and optionally recodes it to twos complement. It then offers the 16-bit word on an output stream.

Four operating states cover channel choice:
- **Single channel.** Every conversion uses the address held in the control register.
- **Shadow load.** The next transfer's word is taken as a per-channel enable mask.
- **Mask sequencing.** Conversions step in ascending order through the enabled channels and wrap around.
- **Count-up sequencing.** Conversions run from channel 0 to the held address and then start again.

A running sequence needs no further register writes. A write whose mode bits select mask sequencing leaves it running. Any other mode write ends it.

The transfer port and the output port are valid/ready streams, and at most one transfer is in flight. `xfer_ready` is high only when no conversion is pending and no word is waiting to be read. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new transfer is accepted. The converter side is plain: `conv_req` stays high until a one-cycle `res_valid` strobe arrives, and `mux_ch` holds steady throughout.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset, `mux_ch` is 0, `conv_req` and `out_valid` are low and `xfer_ready` is high. The block is in single-channel mode at address 0 with straight-binary coding and an all-zero channel mask.
- R2: A transfer is accepted only when `xfer_valid` and `xfer_ready` are both high. `conv_req` then rises on the next cycle and stays high, with `mux_ch` stable, until `res_valid`. `out_valid` rises on the cycle after `res_valid`. `xfer_ready` is low while `conv_req` or `out_valid` is high. `out_word` stays stable while `out_ready` is low.
- R3: Control-word field positions are: write enable at bit 15, sequence bit at bit 14, shadow bit at bit 13, channel address at bits 12:9 and coding bit at bit 8. A write with sequence=0 and shadow=0 converts the written address on that transfer and on every later transfer.
- R4: A write with sequence=1 and shadow=0, made from single-channel mode, starts mask sequencing. That transfer converts the lowest enabled channel, and each later transfer converts the next higher enabled channel.
- R5: In mask sequencing, the transfer after the highest enabled channel converts the lowest enabled channel again.
- R6: A write with sequence=1 and shadow=1 starts count-up sequencing. That transfer converts channel 0, each later transfer converts the previous channel plus one, and the transfer after the written address converts channel 0 again. The mask has no effect on this mode.
- R7: A word with bit 15 clear changes no stored setting. Its other bits have no effect, and a running sequence takes its next step.
- R8: During mask or count-up sequencing, a write with sequence=1 and shadow=0 updates only the coding bit, and the sequence takes its next step. A write with any other mode-bit pair ends the sequence or restarts it.
- R9: A write with sequence=0 and shadow=1 converts the written address. The whole 16-bit word of the next transfer is stored as the mask, with bit i enabling channel i, and that transfer converts the held address. The transfer after the load converts the lowest enabled channel.
- R10: In mask sequencing with an all-zero mask, each transfer converts the held address.
- R11: `out_word` bits 15:12 carry the converted channel and bits 11:0 carry the result.
- R12: With coding bit 0 the result is passed through unchanged. With coding bit 1, result bit 11 is inverted, which gives twos complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A transfer word is offered |
| xfer_ready | output | 1 | The block can accept a transfer |
| xfer_word | input | 16 | Control word, or mask word after a shadow-load write |
| mux_ch | output | 4 | Channel select for the analog multiplexer |
| conv_req | output | 1 | A conversion on `mux_ch` is requested |
| res_valid | input | 1 | One-cycle strobe: conversion result present |
| res_data | input | 12 | Straight-binary conversion result |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 16 | Channel tag and coded result |

## Verification
Every piece of state this block keeps shows up one cycle after the transfer that uses it. A wrong mode, held address, mask, last channel or restart flag produces a wrong `mux_ch` on the cycle `conv_req` rises, and the same wrong value appears in the top nibble of `out_word`. A wrong coding bit flips bit 11 of the very next output word. A stuck phase shows at once as `xfer_ready`, `conv_req` or `out_valid` disagreeing with the handshake history. Some errors stay hidden until the next wrap or mode change: a sequencing pointer that goes wrong only at the highest channel, or a missed restart. For this reason the bench runs each sequence for more than two full laps and crosses every mode transition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_SHLOAD = 2'd1,
    MD_MASK   = 2'd2,
    MD_CONSEC = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_OUT  = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [NUM_CH-1:0] word,
  input  logic [CH_W-1:0]   sel_ch,
  output seq_mode_e         conv_mode,
  output logic [CH_W-1:0]   eff_addr,
  output logic [CH_W-1:0]   eff_last,
  output logic              eff_fresh,
  output logic [NUM_CH-1:0] eff_mask,
  output logic              eff_rng
);
  localparam int WR_BIT  = NUM_CH - 1;
  localparam int SEQ_BIT = NUM_CH - 2;
  localparam int SHD_BIT = NUM_CH - 3;
  localparam int ADR_HI  = NUM_CH - 4;
  localparam int ADR_LO  = ADR_HI - CH_W + 1;
  localparam int RNG_BIT = ADR_LO - 1;

  seq_mode_e         mode_q, mode_d;
  logic [CH_W-1:0]   addr_q, addr_d;
  logic [CH_W-1:0]   last_q;
  logic              rng_q, rng_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              fresh_q, fresh_after, restart;

  always_comb begin
    mode_d      = mode_q;
    addr_d      = addr_q;
    rng_d       = rng_q;
    mask_d      = mask_q;
    conv_mode   = mode_q;
    restart     = 1'b0;
    fresh_after = 1'b0;
    if (mode_q == MD_SHLOAD) begin
      mask_d      = word;
      mode_d      = MD_MASK;
      conv_mode   = MD_SINGLE;
      fresh_after = 1'b1;
    end else begin
      if (word[WR_BIT]) begin
        rng_d = word[RNG_BIT];
        unique case ({word[SEQ_BIT], word[SHD_BIT]})
          2'b10: begin
            if (mode_q == MD_SINGLE) begin
              mode_d  = MD_MASK;
              addr_d  = word[ADR_HI:ADR_LO];
              restart = 1'b1;
            end
          end
          2'b11: begin
            mode_d  = MD_CONSEC;
            addr_d  = word[ADR_HI:ADR_LO];
            restart = 1'b1;
          end
          2'b00: begin
            mode_d = MD_SINGLE;
            addr_d = word[ADR_HI:ADR_LO];
          end
          default: begin
            mode_d = MD_SHLOAD;
            addr_d = word[ADR_HI:ADR_LO];
          end
        endcase
      end
      conv_mode = (mode_d == MD_SHLOAD) ? MD_SINGLE : mode_d;
    end
  end

  assign eff_addr  = addr_d;
  assign eff_last  = last_q;
  assign eff_fresh = fresh_q | restart;
  assign eff_mask  = mask_d;
  assign eff_rng   = rng_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_SINGLE;
      addr_q  <= '0;
      rng_q   <= 1'b0;
      mask_q  <= '0;
      last_q  <= '0;
      fresh_q <= 1'b1;
    end else if (fire) begin
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      rng_q   <= rng_d;
      mask_q  <= mask_d;
      last_q  <= sel_ch;
      fresh_q <= fresh_after;
    end
  end
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  seq_mode_e         conv_mode,
  input  logic [CH_W-1:0]   addr,
  input  logic [CH_W-1:0]   last,
  input  logic              fresh,
  input  logic [NUM_CH-1:0] mask,
  output logic [CH_W-1:0]   sel_ch
);
  logic [NUM_CH-1:0] above;
  logic [CH_W-1:0]   lo_above, lo_any, count_next;
  logic              hit_above, hit_any;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_above
    localparam logic [CH_W-1:0] IDX = CH_W'(gi);
    assign above[gi] = mask[gi] && (fresh || (IDX > last));
  end

  always_comb begin
    lo_above  = '0;
    hit_above = 1'b0;
    lo_any    = '0;
    hit_any   = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (above[i]) begin
        lo_above  = CH_W'(i);
        hit_above = 1'b1;
      end
      if (mask[i]) begin
        lo_any  = CH_W'(i);
        hit_any = 1'b1;
      end
    end
  end

  always_comb begin
    if (fresh || (last >= addr)) count_next = '0;
    else                         count_next = last + {{(CH_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    unique case (conv_mode)
      MD_MASK: begin
        if (!hit_any)       sel_ch = addr;
        else if (hit_above) sel_ch = lo_above;
        else                sel_ch = lo_any;
      end
      MD_CONSEC: sel_ch = count_next;
      default:   sel_ch = addr;
    endcase
  end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int CH_W  = 4,
  parameter int RES_W = 12,
  localparam int OUT_W = CH_W + RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CH_W-1:0]  ch,
  input  logic [RES_W-1:0] res,
  input  logic             rng,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);
  logic [RES_W-1:0] flip;
  assign flip = {rng, {(RES_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= {ch, res ^ flip};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OUT_W = CH_W + RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [NUM_CH-1:0] xfer_word,
  output logic [CH_W-1:0]   mux_ch,
  output logic              conv_req,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_word
);
  seq_phase_e        phase_q;
  seq_mode_e         conv_mode;
  logic [CH_W-1:0]   eff_addr, eff_last, sel_ch, ch_q;
  logic [NUM_CH-1:0] eff_mask;
  logic              eff_fresh, eff_rng, fire, res_take;

  assign xfer_ready = (phase_q == PH_IDLE);
  assign conv_req   = (phase_q == PH_CONV);
  assign fire       = xfer_valid && xfer_ready;
  assign res_take   = conv_req && res_valid;
  assign mux_ch     = ch_q;

  adc_seq_cfg #(.NUM_CH(NUM_CH)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .word      (xfer_word),
    .sel_ch    (sel_ch),
    .conv_mode (conv_mode),
    .eff_addr  (eff_addr),
    .eff_last  (eff_last),
    .eff_fresh (eff_fresh),
    .eff_mask  (eff_mask),
    .eff_rng   (eff_rng)
  );

  adc_seq_pick #(.NUM_CH(NUM_CH)) pick_i (
    .conv_mode (conv_mode),
    .addr      (eff_addr),
    .last      (eff_last),
    .fresh     (eff_fresh),
    .mask      (eff_mask),
    .sel_ch    (sel_ch)
  );

  adc_seq_fmt #(.CH_W(CH_W), .RES_W(RES_W)) fmt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (res_take),
    .ch        (ch_q),
    .res       (res_data),
    .rng       (eff_rng),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ch_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (fire) begin
          phase_q <= PH_CONV;
          ch_q    <= sel_ch;
        end
        PH_CONV: if (res_valid) phase_q <= PH_OUT;
        PH_OUT:  if (out_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk #(
  parameter int CH_W  = 4,
  parameter int RES_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xfer_ready,
  input logic [CH_W-1:0]       mux_ch,
  input logic                  conv_req,
  input logic                  res_valid,
  input logic [RES_W-1:0]      res_data,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [CH_W+RES_W-1:0] out_word
);
  // R2
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !xfer_ready);

  // R2
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !res_valid) |=> (conv_req && $stable(mux_ch)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R2
  out_after_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && res_valid) |=> (out_valid && !conv_req));

  // R11
  out_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[CH_W+RES_W-1:RES_W] == mux_ch));

  // R11
  res_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_word[RES_W-2:0] == $past(res_data[RES_W-2:0])));
endmodule

bind adc_chan_seq adc_chan_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_ready (xfer_ready),
  .mux_ch     (mux_ch),
  .conv_req   (conv_req),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_word   (out_word)
);

// File: tb/adc_chan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_chan_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [15:0] xfer_word = '0;
  logic [3:0]  mux_ch;
  logic        conv_req;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  int m_mode = 0;   // 0 single, 1 shadow-load pending, 2 mask, 3 count-up
  int m_addr = 0;
  int m_rng = 0;
  int m_shadow = 0;
  int m_last = 0;
  bit m_fresh = 1'b1;
  int rseed = 12'h5A3;
  int nx = 0;

  always #2.5 clk = ~clk;

  adc_chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_word(xfer_word), .mux_ch(mux_ch), .conv_req(conv_req),
    .res_valid(res_valid), .res_data(res_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic [15:0] w, output int ch);
    bit restart;
    restart = 1'b0;
    if (m_mode == 1) begin
      m_shadow = int'(w);
      m_mode   = 2;
      ch       = m_addr;
      m_last   = ch;
      m_fresh  = 1'b1;
    end else begin
      if (w[15]) begin
        m_rng = int'(w[8]);
        if (w[14] && !w[13]) begin
          if (m_mode == 0) begin m_mode = 2; m_addr = int'(w[12:9]); restart = 1'b1; end
        end else if (w[14] && w[13]) begin
          m_mode = 3; m_addr = int'(w[12:9]); restart = 1'b1;
        end else if (!w[14] && !w[13]) begin
          m_mode = 0; m_addr = int'(w[12:9]);
        end else begin
          m_mode = 1; m_addr = int'(w[12:9]);
        end
      end
      if (restart) m_fresh = 1'b1;
      ch = m_addr;
      if (m_mode == 2 && m_shadow != 0) begin
        for (int k = 0; k < 16; k++) begin
          int c;
          c = m_fresh ? k : (m_last + 1 + k) % 16;
          if (((m_shadow >> c) & 1) == 1) begin ch = c; break; end
        end
      end else if (m_mode == 3) begin
        ch = (m_fresh || m_last == m_addr) ? 0 : m_last + 1;
      end
      m_last  = ch;
      m_fresh = 1'b0;
    end
  endtask

  task automatic xfer(input logic [15:0] w, input string tag);
    int exp_ch, r, exp_word;
    bit probe;
    probe = (nx % 7) == 3;
    nx++;
    model_step(w, exp_ch);
    rseed = (rseed * 1103 + 2531) % 4096;
    r = (nx % 11 == 0) ? 12'hFFF : (nx % 13 == 0) ? 12'h800 : (nx % 17 == 0) ? 0 : rseed;
    @(negedge clk);
    chk(xfer_ready === 1'b1, "R2", "xfer_ready idle", int'(xfer_ready), 1);
    xfer_valid = 1'b1;
    xfer_word  = w;
    @(negedge clk);
    xfer_valid = 1'b0;
    chk(conv_req === 1'b1, "R2", "conv_req after accept", int'(conv_req), 1);
    chk(mux_ch == 4'(exp_ch), tag, "channel", int'(mux_ch), exp_ch);
    if (probe) begin
      chk(xfer_ready === 1'b0, "R2", "xfer_ready while converting", int'(xfer_ready), 0);
      xfer_valid = 1'b1;
      xfer_word  = 16'hFFFF;
      @(negedge clk);
      xfer_valid = 1'b0;
      chk(conv_req === 1'b1, "R2", "conv_req held", int'(conv_req), 1);
      chk(mux_ch == 4'(exp_ch), "R2", "mux_ch held", int'(mux_ch), exp_ch);
    end
    res_valid = 1'b1;
    res_data  = 12'(r);
    @(negedge clk);
    res_valid = 1'b0;
    exp_word = (exp_ch << 12) | (r ^ (m_rng != 0 ? 12'h800 : 0));
    chk(out_valid === 1'b1, "R2", "out_valid after result", int'(out_valid), 1);
    chk(conv_req === 1'b0, "R2", "conv_req dropped", int'(conv_req), 0);
    chk(int'(out_word) == exp_word, m_rng != 0 ? "R12" : "R11", "out_word",
        int'(out_word), exp_word);
    if (probe) begin
      @(negedge clk);
      chk(int'(out_word) == exp_word && out_valid, "R2", "out_word held under stall",
          int'(out_word), exp_word);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R2", "out_valid after take", int'(out_valid), 0);
  endtask

  function automatic logic [15:0] cw(int seq, int shd, int addr, int rng);
    return 16'h8000 | 16'(seq << 14) | 16'(shd << 13) | 16'((addr & 15) << 9) | 16'((rng & 1) << 8);
  endfunction

  function automatic logic [15:0] nowr(int junk);
    return 16'(junk) & 16'h7FFF;
  endfunction

  task automatic load_mask(int mask, int addr);
    xfer(cw(0, 1, addr, 0), "R9");
    xfer(16'(mask), "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mux_ch == 0, "R1", "reset mux_ch", int'(mux_ch), 0);
    chk(conv_req === 1'b0, "R1", "reset conv_req", int'(conv_req), 0);
    chk(out_valid === 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(xfer_ready === 1'b1, "R1", "reset xfer_ready", int'(xfer_ready), 1);
    xfer(nowr(16'h7FFF), "R1");
    xfer(cw(1, 0, 9, 0), "R10");
    xfer(nowr(0), "R10");

    // single-channel sweep, both codings
    for (int a = 0; a < 16; a++) begin
      for (int g = 0; g < 2; g++) begin
        xfer(cw(0, 0, a, g), "R3");
        xfer(nowr(a * 4099), "R7");
      end
    end

    // count-up sweep with a non-empty mask present
    load_mask(16'h0F0F, 3);
    xfer(cw(0, 0, 0, 0), "R3");
    for (int e = 0; e < 16; e++) begin
      xfer(cw(1, 1, e, e & 1), "R6");
      for (int s = 0; s < 2 * (e + 1) + 1; s++) xfer(nowr(s * 977 + e), "R6");
    end

    // mask sweep: one-hot, computed patterns, full, ends, empty
    for (int i = 0; i < 40; i++) begin
      int mk;
      if (i < 16)       mk = 1 << i;
      else if (i < 36)  mk = ((i * 40503) + 4660) & 16'hFFFF;
      else if (i == 36) mk = 16'hFFFF;
      else if (i == 37) mk = 16'h8001;
      else if (i == 38) mk = 16'h0000;
      else              mk = 16'h7FFE;
      load_mask(mk, i & 15);
      for (int s = 0; s < 2 * $countones(16'(mk)) + 2; s++)
        xfer(nowr(i * 31 + s), mk == 0 ? "R10" : "R5");
    end

    // entering mask from single via mode write, then mid-sequence writes
    load_mask(16'h0A5A, 2);
    xfer(cw(0, 0, 6, 0), "R3");
    xfer(cw(1, 0, 6, 0), "R4");
    xfer(nowr(5), "R4");
    xfer(cw(1, 0, 14, 1), "R8");
    xfer(nowr(0), "R8");
    xfer(cw(1, 0, 1, 0), "R8");
    xfer(cw(1, 1, 4, 0), "R8");
    xfer(nowr(0), "R6");
    xfer(cw(1, 0, 12, 1), "R8");
    xfer(nowr(0), "R8");
    xfer(nowr(0), "R8");
    xfer(nowr(0), "R8");
    xfer(cw(1, 1, 2, 0), "R8");
    xfer(cw(0, 0, 13, 1), "R8");
    xfer(nowr(0), "R3");
    xfer(cw(1, 0, 0, 0), "R4");
    for (int s = 0; s < 12; s++) xfer(nowr(s), "R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule